// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The engine works through a ring of 64 transmit descriptors held in memory. Each descriptor is 128 bytes. Software fills descriptors and then writes a producer index, which is the slot one past the last filled descriptor. The engine reads each pending descriptor's command word and then the pointer words marked valid. It collects the frame bytes from an inline area inside the descriptor, followed by up to three 8-byte-aligned memory segments. It sends the bytes one per handshake to a MAC transmit port. When a frame is done, the engine writes a completion status over the command word, advances its consumer index and updates three sticky status flags that drive an interrupt.

Memory is reached through a single request port. Reads are answered later by a response strobe. Writes are posted. The engine has at most one read outstanding at a time. The collision count and the late-collision indication come from the MAC as plain inputs. The engine samples them when it writes the status.

The controller is one state machine with these states:
- `S_IDLE`: waits until the consumer index differs from the producer index.
- `S_CMD_REQ`, then `S_CMD_WAIT`: reads the command word.
- `S_PTR_REQ` and `S_PTR_WAIT`: loop over the three pointer slots. Slots not marked valid are skipped.
- `S_SEG_PICK`: selects the next non-empty segment.
- `S_WORD_REQ`, then `S_WORD_WAIT`: fetch one 64-bit word.
- `S_SEND`: outputs bytes. It returns to `S_WORD_REQ` at a word boundary, or to `S_SEG_PICK` when the segment ends.
- `S_WRITEBACK`: writes the status word. It goes to `S_IDLE`, or to `S_HALT` when the frame length was wrong and the command asked to stop.
- `S_HALT`: leaves for `S_IDLE` once software clears the abort flag.

Top module: `txring_engine`

## Requirements
- R1: Descriptor `i` sits at byte address `ring_base*8192 + i*128`. The consumer index counts 0..63 and then wraps to 0.
- R2: A pulse on `prod_wr` loads `prod_idx`. The engine processes descriptors, one at a time, while its consumer index differs from that value. The consumer index advances by one per written-back status.
- R3: Command bits 15:0 hold the frame length minus one. Bits 22:16 hold the inline start offset. The inline bytes run from that offset through byte 127 of the descriptor. An offset below 32 means the frame has no inline bytes.
- R4: Command bits 25, 26 and 27 mark pointer words 1, 2 and 3 (at descriptor bytes 8, 16 and 24) as valid. A pointer word holds an address in bits 31:3 and the length minus one in bits 47:32. Pointer words not marked valid are neither read nor sent.
- R5: Bytes leave in this order: inline bytes, then segments 1, 2 and 3. Within a 64-bit memory word, the byte at address offset k is bits 8k+7:8k. `tx_last` marks the final byte of the frame.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold steady.
- R7: The status word written over the command word has these fields:
  - bit 63 set;
  - bits 15:0 the number of bytes sent;
  - bits 19:16 `mac_col_cnt`;
  - bit 20 `mac_late_col`;
  - bit 23 success, meaning the length matched and there was no late collision;
  - all other bits zero, apart from those given in R8.
- R8: If the gathered byte count exceeds the command length, status bit 24 is set. If it falls short, status bit 25 is set. In either case success is 0.
- R9: A length mismatch in a frame whose command bit 23 is set halts the engine after write-back. It then reads nothing until the abort flag is cleared, and then resumes with the next descriptor.
- R10: `int_status` reports the following. Bits 2:0 and 22:16 are the only bits that can be non-zero.
  - bit 0, ring empty: set when a write-back makes the consumer index equal the producer index;
  - bit 1, frame sent: set when a write-back completes a frame with command bit 24;
  - bit 2, abort: set when a write-back has a length mismatch;
  - bits 22:16: the consumer index.
- R11: Writing a 1 to a bit of `flag_clr` clears that flag; a set in the same cycle wins. `irq` is high exactly when some flag is set and its `irq_en` bit is 1.
- R12: After reset, the engine behaves as follows until the first producer write:
  - `mem_req`, `tx_valid` and `irq` are low;
  - `int_status` is zero;
  - the engine stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | 19 | Ring base address bits 31:13 |
| prod_wr | input | 1 | Producer index write strobe |
| prod_idx | input | 6 | New producer index |
| flag_clr | input | 3 | Write-one-to-clear for the three flags |
| irq_en | input | 3 | Per-flag interrupt enable |
| mac_col_cnt | input | 4 | Collision count reported by the MAC |
| mac_late_col | input | 1 | Late-collision indication from the MAC |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, 8-byte aligned |
| mem_wdata | output | 64 | Write data |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 64 | Read response data |
| tx_valid | output | 1 | Byte available to the MAC |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC accepts the byte |
| int_status | output | 32 | Flags and consumer index |
| irq | output | 1 | Interrupt request |

## Verification
Each kind of internal error shows up at the ports as follows:
- A wrong segment table entry or wrong byte cursor puts bytes that do not match the memory pattern on `tx_data` within the same frame.
- A miscounted byte total shows up in the written-back status, and in a misplaced `tx_last`, by the end of that frame.
- A wrong consumer index is visible in `int_status` bits 22:16 as soon as a write-back happens. It also sends the next status write to the wrong descriptor address.
- A stuck halt or a lost flag shows up within a few cycles as a frozen index or a wrong `irq` level.

The stimulus varies several things from frame to frame:
- inline offsets, including unaligned ones and ones below 32;
- pointer masks with gaps;
- frames that are too long and frames that are too short;
- a MAC that stalls on every third cycle;
- a run that wraps the ring.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int DESC_BYTES = 128;
    localparam int HDR_BYTES  = 32;
    localparam int NUM_SEG    = 4;
    localparam int NUM_FLAG   = 3;

    localparam int FLAG_EMPTY = 0;
    localparam int FLAG_SENT  = 1;
    localparam int FLAG_ABORT = 2;

    localparam int CMD_OFS_LO   = 16;
    localparam int CMD_STOP_BIT = 23;
    localparam int CMD_IRQ_BIT  = 24;
    localparam int CMD_PTR0_BIT = 25;

    localparam int ST_COL_LO   = 16;
    localparam int ST_LATE     = 20;
    localparam int ST_SUCCESS  = 23;
    localparam int ST_TOO_BIG  = 24;
    localparam int ST_UNDERRUN = 25;
    localparam int ST_DONE     = 63;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD_REQ, S_CMD_WAIT, S_PTR_REQ, S_PTR_WAIT, S_SEG_PICK,
        S_WORD_REQ, S_WORD_WAIT, S_SEND, S_WRITEBACK, S_HALT
    } eng_state_t;
endpackage

// File: rtl/txr_seg_table.sv
module txr_seg_table #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int NSEG   = 4,
    parameter int TOT_W  = 18,
    localparam int SEL_W = $clog2(NSEG) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LEN_W:0]    wr_len,
    input  logic [SEL_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LEN_W:0]    rd_len,
    output logic              rd_valid,
    output logic [TOT_W-1:0]  total
);
    logic [ADDR_W-1:0] addr_arr [NSEG];
    logic [LEN_W:0]    len_arr  [NSEG];
    logic [NSEG-1:0]   vld_arr;

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        logic [ADDR_W-1:0] a_q;
        logic [LEN_W:0]    l_q;
        logic              v_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                a_q <= '0;
                l_q <= '0;
                v_q <= 1'b0;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (wr_en && wr_idx == SEL_W'(g)) begin
                a_q <= wr_addr;
                l_q <= wr_len;
                v_q <= 1'b1;
            end
        end
        assign addr_arr[g] = a_q;
        assign len_arr[g]  = l_q;
        assign vld_arr[g]  = v_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     total <= '0;
        else if (clr)   total <= '0;
        else if (wr_en) total <= total + TOT_W'(wr_len);
    end

    always_comb begin
        rd_addr  = '0;
        rd_len   = '0;
        rd_valid = 1'b0;
        for (int k = 0; k < NSEG; k++) begin
            if (rd_idx == SEL_W'(k)) begin
                rd_addr  = addr_arr[k];
                rd_len   = len_arr[k];
                rd_valid = vld_arr[k];
            end
        end
    end
endmodule

// File: rtl/txr_status.sv
module txr_status
    import txr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_FLAG-1:0] set_i,
    input  logic [NUM_FLAG-1:0] clr_i,
    input  logic [NUM_FLAG-1:0] en_i,
    input  logic [IDX_W-1:0]    cons_i,
    output logic [NUM_FLAG-1:0] flags_o,
    output logic [31:0]         int_status_o,
    output logic                irq_o
);
    logic [NUM_FLAG-1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o      = flags_q;
    assign irq_o        = |(flags_q & en_i);
    assign int_status_o = (32'(cons_i) << 16) | 32'(flags_q);

    // R11: a clear without a simultaneous set removes the abort flag
    a_r11_abort_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[FLAG_ABORT] && !set_i[FLAG_ABORT]) |=> !flags_o[FLAG_ABORT]);
    // R10: a flag never appears without its set strobe
    a_r10_sent_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[FLAG_SENT]) |-> $past(set_i[FLAG_SENT]));
endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import txr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int RING_DEPTH = 64,
    parameter int LEN_W      = 16,
    localparam int IDX_W     = $clog2(RING_DEPTH),
    localparam int OFS_W     = $clog2(DESC_BYTES),
    localparam int RB_W      = ADDR_W - IDX_W - OFS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RB_W-1:0]     ring_base,
    input  logic                prod_wr,
    input  logic [IDX_W-1:0]    prod_idx,
    input  logic [NUM_FLAG-1:0] flag_clr,
    input  logic [NUM_FLAG-1:0] irq_en,
    input  logic [3:0]          mac_col_cnt,
    input  logic                mac_late_col,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [63:0]         mem_wdata,
    input  logic                mem_rvalid,
    input  logic [63:0]         mem_rdata,
    output logic                tx_valid,
    output logic [7:0]          tx_data,
    output logic                tx_last,
    input  logic                tx_ready,
    output logic [31:0]         int_status,
    output logic                irq
);
    localparam int TOT_W = LEN_W + 2;
    localparam int SEL_W = $clog2(NUM_SEG) + 1;

    eng_state_t state_q, state_d;
    logic [IDX_W-1:0]    prod_q, cons_q;
    logic [LEN_W-1:0]    len_q;
    logic                stop_q, irqreq_q;
    logic [2:0]          pvld_q;
    logic [1:0]          ptr_sel;
    logic [SEL_W-1:0]    seg_q;
    logic [ADDR_W-1:0]   cur_addr;
    logic [LEN_W:0]      remain;
    logic [TOT_W-1:0]    left_q, sent_cnt;
    logic [63:0]         word_q;

    logic [ADDR_W-1:0]   desc_addr;
    logic [OFS_W-1:0]    rd_ofs;
    logic                tb_clr, tb_wr;
    logic [SEL_W-1:0]    tb_idx;
    logic [ADDR_W-1:0]   tb_addr, seg_addr;
    logic [LEN_W:0]      tb_len, seg_len;
    logic                seg_vld;
    logic [TOT_W-1:0]    seg_total, want_len;
    logic                too_big, too_short, mismatch;
    logic [NUM_FLAG-1:0] flag_set, flags;

    assign desc_addr = {ring_base, cons_q, OFS_W'(0)};
    assign rd_ofs    = mem_rdata[CMD_OFS_LO +: OFS_W];
    assign want_len  = TOT_W'(len_q) + TOT_W'(1);
    assign too_big   = sent_cnt > want_len;
    assign too_short = sent_cnt < want_len;
    assign mismatch  = too_big || too_short;

    txr_seg_table #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NSEG(NUM_SEG), .TOT_W(TOT_W)) u_segs (
        .clk(clk), .rst_n(rst_n), .clr(tb_clr), .wr_en(tb_wr), .wr_idx(tb_idx),
        .wr_addr(tb_addr), .wr_len(tb_len), .rd_idx(seg_q), .rd_addr(seg_addr),
        .rd_len(seg_len), .rd_valid(seg_vld), .total(seg_total)
    );

    txr_status #(.IDX_W(IDX_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr), .en_i(irq_en),
        .cons_i(cons_q), .flags_o(flags), .int_status_o(int_status), .irq_o(irq)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (cons_q != prod_q) state_d = S_CMD_REQ;
            S_CMD_REQ:   state_d = S_CMD_WAIT;
            S_CMD_WAIT:  if (mem_rvalid) state_d = S_PTR_REQ;
            S_PTR_REQ:   if (ptr_sel == 2'd3) state_d = S_SEG_PICK;
                         else if (pvld_q[ptr_sel]) state_d = S_PTR_WAIT;
            S_PTR_WAIT:  if (mem_rvalid) state_d = S_PTR_REQ;
            S_SEG_PICK:  if (seg_q == SEL_W'(NUM_SEG)) state_d = S_WRITEBACK;
                         else if (seg_vld) state_d = S_WORD_REQ;
            S_WORD_REQ:  state_d = S_WORD_WAIT;
            S_WORD_WAIT: if (mem_rvalid) state_d = S_SEND;
            S_SEND:      if (tx_ready) begin
                             if (remain == (LEN_W+1)'(1)) state_d = S_SEG_PICK;
                             else if (cur_addr[2:0] == 3'd7) state_d = S_WORD_REQ;
                         end
            S_WRITEBACK: state_d = (mismatch && stop_q) ? S_HALT : S_IDLE;
            S_HALT:      if (!flags[FLAG_ABORT]) state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;  prod_q <= '0;   cons_q <= '0;
            len_q <= '0;        stop_q <= 1'b0; irqreq_q <= 1'b0; pvld_q <= '0;
            ptr_sel <= '0;      seg_q <= '0;    cur_addr <= '0;   remain <= '0;
            left_q <= '0;       sent_cnt <= '0; word_q <= '0;
        end else begin
            state_q <= state_d;
            if (prod_wr) prod_q <= prod_idx;
            unique case (state_q)
                S_CMD_REQ:  sent_cnt <= '0;
                S_CMD_WAIT: if (mem_rvalid) begin
                    len_q    <= mem_rdata[LEN_W-1:0];
                    stop_q   <= mem_rdata[CMD_STOP_BIT];
                    irqreq_q <= mem_rdata[CMD_IRQ_BIT];
                    pvld_q   <= mem_rdata[CMD_PTR0_BIT +: 3];
                    ptr_sel  <= '0;
                end
                S_PTR_REQ: begin
                    if (ptr_sel == 2'd3) begin
                        seg_q  <= '0;
                        left_q <= seg_total;
                    end else if (!pvld_q[ptr_sel]) begin
                        ptr_sel <= ptr_sel + 2'd1;
                    end
                end
                S_PTR_WAIT: if (mem_rvalid) ptr_sel <= ptr_sel + 2'd1;
                S_SEG_PICK: if (seg_q != SEL_W'(NUM_SEG)) begin
                    if (seg_vld) begin
                        cur_addr <= seg_addr;
                        remain   <= seg_len;
                    end else begin
                        seg_q <= seg_q + SEL_W'(1);
                    end
                end
                S_WORD_WAIT: if (mem_rvalid) word_q <= mem_rdata;
                S_SEND: if (tx_ready) begin
                    cur_addr <= cur_addr + ADDR_W'(1);
                    remain   <= remain - (LEN_W+1)'(1);
                    left_q   <= left_q - TOT_W'(1);
                    sent_cnt <= sent_cnt + TOT_W'(1);
                    if (remain == (LEN_W+1)'(1)) seg_q <= seg_q + SEL_W'(1);
                end
                S_WRITEBACK: cons_q <= cons_q + IDX_W'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tx_valid  = 1'b0;
        tx_data   = '0;
        tx_last   = 1'b0;
        tb_clr    = 1'b0;
        tb_wr     = 1'b0;
        tb_idx    = '0;
        tb_addr   = '0;
        tb_len    = '0;
        flag_set  = '0;
        unique case (state_q)
            S_CMD_REQ: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr;
                tb_clr   = 1'b1;
            end
            S_CMD_WAIT: if (mem_rvalid && int'(rd_ofs) >= HDR_BYTES) begin
                tb_wr   = 1'b1;
                tb_addr = desc_addr + ADDR_W'(rd_ofs);
                tb_len  = (LEN_W+1)'(DESC_BYTES) - (LEN_W+1)'(rd_ofs);
            end
            S_PTR_REQ: if (ptr_sel != 2'd3 && pvld_q[ptr_sel]) begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(8 * (int'(ptr_sel) + 1));
            end
            S_PTR_WAIT: if (mem_rvalid) begin
                tb_wr   = 1'b1;
                tb_idx  = SEL_W'(ptr_sel) + SEL_W'(1);
                tb_addr = ADDR_W'({mem_rdata[31:3], 3'b000});
                tb_len  = (LEN_W+1)'(mem_rdata[32 +: LEN_W]) + (LEN_W+1)'(1);
            end
            S_WORD_REQ: begin
                mem_req  = 1'b1;
                mem_addr = {cur_addr[ADDR_W-1:3], 3'b000};
            end
            S_SEND: begin
                tx_valid = 1'b1;
                tx_data  = word_q[{cur_addr[2:0], 3'b000} +: 8];
                tx_last  = (left_q == TOT_W'(1));
            end
            S_WRITEBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = desc_addr;
                mem_wdata[15:0]              = sent_cnt[15:0];
                mem_wdata[ST_COL_LO +: 4]    = mac_col_cnt;
                mem_wdata[ST_LATE]           = mac_late_col;
                mem_wdata[ST_SUCCESS]        = !mismatch && !mac_late_col;
                mem_wdata[ST_TOO_BIG]        = too_big;
                mem_wdata[ST_UNDERRUN]       = too_short;
                mem_wdata[ST_DONE]           = 1'b1;
                flag_set[FLAG_EMPTY] = (cons_q + IDX_W'(1)) == prod_q;
                flag_set[FLAG_SENT]  = irqreq_q;
                flag_set[FLAG_ABORT] = mismatch;
            end
            default: ;
        endcase
    end

    // R6: offered byte stays put until taken
    a_r6_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
    // R2: never more than one read outstanding
    a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req);
    // R2: consumer index moves only on a status write
    a_r2_cons_on_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_q != $past(cons_q)) |-> $past(mem_req && mem_we));
    // R9: a halted engine is silent
    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT) |-> (!mem_req && !tx_valid));
endmodule

// File: tb/test_txring_engine.sv
`timescale 1ns/1ps
module test_txring_engine;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [18:0] ring_base;
    logic        prod_wr;
    logic [5:0]  prod_idx;
    logic [2:0]  flag_clr, irq_en;
    logic [3:0]  mac_col_cnt;
    logic        mac_late_col;
    logic        mem_req, mem_we, mem_rvalid;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;
    logic        tx_valid, tx_last, tx_ready;
    logic [7:0]  tx_data;
    logic [31:0] int_status;
    logic        irq;

    txring_engine i_txring_engine (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .prod_wr(prod_wr),
        .prod_idx(prod_idx), .flag_clr(flag_clr), .irq_en(irq_en),
        .mac_col_cnt(mac_col_cnt), .mac_late_col(mac_late_col),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .int_status(int_status), .irq(irq)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] mem [4096];
    logic [7:0]  got_q [$];
    logic [7:0]  exp_q [$];
    int          last_pos = -1;
    logic [63:0] exp_st [64];

    typedef struct packed {
        logic [6:0] ofs;
        logic [2:0] vm;
        logic [7:0] l1, l2, l3;
        logic [1:0] adj;
        logic       irqb;
        logic [3:0] col;
        logic       late;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{7'd96,  3'b000, 8'd0,  8'd0, 8'd0,  2'd0, 1'b1, 4'd2,  1'b0},
        '{7'd0,   3'b001, 8'd20, 8'd0, 8'd0,  2'd0, 1'b0, 4'd0,  1'b0},
        '{7'd120, 3'b111, 8'd13, 8'd7, 8'd30, 2'd0, 1'b1, 4'd15, 1'b0},
        '{7'd32,  3'b010, 8'd0,  8'd9, 8'd0,  2'd0, 1'b0, 4'd1,  1'b1},
        '{7'd100, 3'b001, 8'd5,  8'd0, 8'd0,  2'd1, 1'b0, 4'd3,  1'b0},
        '{7'd127, 3'b100, 8'd0,  8'd0, 8'd3,  2'd2, 1'b0, 4'd0,  1'b0},
        '{7'd20,  3'b001, 8'd16, 8'd0, 8'd0,  2'd0, 1'b0, 4'd4,  1'b0}
    };

    function automatic logic [7:0] pat(logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [31:0] daddr(int idx);
        return 32'h2000 + 32'(idx) * 32'd128;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    // memory model: reads answered two negedges after the request
    initial begin
        int pend = 0;
        logic [31:0] ra = '0;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem[ra[14:3]];
                end
            end
            if (mem_req) begin
                if (mem_we) mem[mem_addr[14:3]] = mem_wdata;
                else begin pend = 2; ra = mem_addr; end
            end
        end
    end

    // MAC side: stalls every third cycle, records accepted bytes
    initial begin
        int cyc = 0;
        tx_ready = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            tx_ready = (cyc % 3) != 2;
            #1;
            if (rst_n && tx_valid && tx_ready) begin
                if (tx_last) last_pos = got_q.size();
                got_q.push_back(tx_data);
            end
        end
    end

    task automatic setup_frame(int idx, int ofs, int vm, int l1, int l2, int l3,
                               int adj, int irqb, int stopb, int col, int late);
        int lens [3];
        int total;
        int cmdlen;
        logic [31:0] pa;
        logic [63:0] cmd, st;
        lens[0] = l1; lens[1] = l2; lens[2] = l3;
        total = 0;
        if (ofs >= 32) begin
            for (int a = ofs; a < 128; a++) exp_q.push_back(pat(daddr(idx) + 32'(a)));
            total = 128 - ofs;
        end
        for (int k = 0; k < 3; k++) begin
            pa = 32'h4000 + 32'(((idx % 16) * 3 + k) * 128);
            if (vm[k]) begin
                mem[(daddr(idx) >> 3) + 1 + k] = (64'(lens[k] - 1) << 32) | 64'(pa);
                for (int a = 0; a < lens[k]; a++) exp_q.push_back(pat(pa + 32'(a)));
                total += lens[k];
            end else begin
                mem[(daddr(idx) >> 3) + 1 + k] = 64'h0;
            end
        end
        cmdlen = total + (adj == 1 ? -1 : (adj == 2 ? 1 : 0));
        cmd = 64'(16'(cmdlen - 1)) | (64'(ofs) << 16) | (64'(stopb) << 23)
            | (64'(irqb) << 24) | (64'(vm) << 25);
        mem[daddr(idx) >> 3] = cmd;
        st = 64'h8000_0000_0000_0000 | 64'(16'(total)) | (64'(col) << 16) | (64'(late) << 20);
        if (total > cmdlen) st[24] = 1'b1;
        if (total < cmdlen) st[25] = 1'b1;
        if (total == cmdlen && late == 0) st[23] = 1'b1;
        exp_st[idx] = st;
    endtask

    task automatic push_prod(int v);
        @(negedge clk);
        prod_wr  = 1'b1;
        prod_idx = 6'(v);
        @(negedge clk);
        prod_wr = 1'b0;
    endtask

    task automatic wait_cons(int t);
        for (int i = 0; i < 20000 && int_status[22:16] != 7'(t); i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_bytes(string tag);
        bit ok;
        ok = got_q.size() == exp_q.size();
        if (ok) foreach (exp_q[i]) if (got_q[i] != exp_q[i]) ok = 1'b0;
        chk(ok, {tag, " R5 R6 byte stream"}, got_q.size(), exp_q.size());
        if (exp_q.size() > 0)
            chk(last_pos == exp_q.size() - 1, {tag, " R5 tx_last position"}, last_pos, exp_q.size() - 1);
    endtask

    task automatic clear_stream();
        got_q.delete();
        exp_q.delete();
        last_pos = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 4096; w++)
            for (int b = 0; b < 8; b++) mem[w][8*b +: 8] = pat(32'(w * 8 + b));
        rst_n = 1'b0; ring_base = 19'd1; prod_wr = 1'b0; prod_idx = '0;
        flag_clr = '0; irq_en = '0; mac_col_cnt = '0; mac_late_col = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R12 reset state
        chk(!mem_req && !tx_valid, "R12 idle outputs", {mem_req, tx_valid}, 0);
        chk(!irq, "R12 irq low", irq, 0);
        chk(int_status == 32'h0, "R12 int_status", int_status, 0);

        // vector table: one frame per entry, ring slots 0..6
        for (int v = 0; v < NVEC; v++) begin
            clear_stream();
            mac_col_cnt  = VECS[v].col;
            mac_late_col = VECS[v].late;
            setup_frame(v, VECS[v].ofs, VECS[v].vm, VECS[v].l1, VECS[v].l2, VECS[v].l3,
                        VECS[v].adj, VECS[v].irqb, 0, VECS[v].col, VECS[v].late);
            push_prod(v + 1);
            wait_cons(v + 1);
            cmp_bytes($sformatf("vec%0d R3 R4", v));
            chk(mem[daddr(v) >> 3] == exp_st[v], $sformatf("vec%0d R7 R8 status", v),
                mem[daddr(v) >> 3], exp_st[v]);
            chk(int_status[22:16] == 7'(v + 1), $sformatf("vec%0d R2 consumer", v),
                int_status[22:16], v + 1);
        end

        // R10 flags after the table: empty, sent and abort all raised
        chk(int_status == 32'h0007_0007, "R10 flags and index", int_status, 32'h0007_0007);
        chk(!irq, "R11 irq masked", irq, 0);
        @(negedge clk); irq_en = 3'b010; #1;
        chk(irq, "R11 irq on enabled sent flag", irq, 1);
        flag_clr = 3'b111; @(negedge clk); flag_clr = 3'b000; #1;
        chk(int_status[2:0] == 3'b000 && !irq, "R11 write-one clear", int_status[2:0], 0);

        // R9 stop on abort: slot 7 too short with stop bit, slot 8 good
        irq_en = 3'b100;
        mac_col_cnt = 4'd0; mac_late_col = 1'b0;
        clear_stream();
        setup_frame(7, 96, 0, 0, 0, 0, 2, 0, 1, 0, 0);
        push_prod(9);
        wait_cons(8);
        repeat (100) @(negedge clk);
        chk(int_status[22:16] == 7'd8, "R9 halted consumer", int_status[22:16], 8);
        chk(int_status[2] && irq, "R9 R11 abort flag raises irq", {int_status[2], irq}, 3);
        chk(mem[daddr(7) >> 3] == exp_st[7], "R9 R8 underrun status", mem[daddr(7) >> 3], exp_st[7]);
        clear_stream();
        setup_frame(8, 112, 1, 10, 0, 0, 0, 0, 0, 0, 0);
        flag_clr = 3'b100; @(negedge clk); flag_clr = 3'b000;
        wait_cons(9);
        cmp_bytes("R9 resumed");
        chk(mem[daddr(8) >> 3] == exp_st[8], "R9 R7 resumed status", mem[daddr(8) >> 3], exp_st[8]);
        chk(!irq && int_status[0], "R10 R11 empty set, abort gone", {irq, int_status[0]}, 1);

        // R1 wrap: slots 9..63 then 0 and 1
        irq_en = 3'b000;
        clear_stream();
        for (int i = 9; i < 66; i++) setup_frame(i % 64, 120, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        push_prod(2);
        wait_cons(2);
        cmp_bytes("R1 wrap");
        chk(int_status[22:16] == 7'd2, "R1 consumer wrapped", int_status[22:16], 2);
        chk(mem[daddr(63) >> 3] == exp_st[63], "R1 slot 63 status", mem[daddr(63) >> 3], exp_st[63]);
        chk(mem[daddr(0) >> 3] == exp_st[0] && mem[daddr(1) >> 3] == exp_st[1],
            "R1 slots 0 and 1 status", mem[daddr(1) >> 3], exp_st[1]);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule